// File: doc/BRIEF.md
# Single-to-Double Precision Float Widener

This block turns a 32-bit IEEE-754 binary32 word into the binary64 word that holds the same value, bit for bit. Every binary32 value has an exact binary64 form, so no rounding is done. A small front end sorts the input magnitude into one of four classes: zero, subnormal, normal, or infinity/NaN. Shift-and-rebias logic then builds the wider word for that class.

Normal inputs move their fraction up into the wider field, and their exponent is rebiased by 896. Subnormal inputs are renormalized. A leading-zero count finds the top set bit of the fraction. The fraction is shifted so that this bit lands on the hidden-bit position and is dropped, and the exponent is lowered to match. Infinities and NaNs get an all-ones exponent and keep their payload, left-aligned in the wider fraction. The quiet bit is copied unchanged, so a signaling NaN stays signaling. The sign moves from bit 31 to bit 63 for every class.

The result is registered once. A valid strobe travels alongside the data. The output word updates only on cycles where the input is valid.

Top module: `f32_to_f64_widen`

## Requirements
- R1: For a normal input (exponent field in[30:23] between 1 and 254), out[62:52] equals in[30:23] + 896, out[51:29] equals in[22:0], and out[28:0] is zero.
- R2: For a subnormal input (in[30:23] = 0, in[22:0] nonzero) whose top set fraction bit is bit k, out[62:52] equals 874 + k. out[51:0] holds the fraction bits below bit k, left-aligned so that bit k-1 lands at bit 51, with zeros below. The input 0x0000_0001 gives 0x36A0_0000_0000_0000.
- R3: A zero magnitude (in[30:0] = 0) gives out[62:0] = 0.
- R4: An infinity (in[30:23] = 255, in[22:0] = 0) gives out[62:52] = 2047 and out[51:0] = 0.
- R5: A NaN (in[30:23] = 255, in[22:0] nonzero) gives out[62:52] = 2047 and out[51:29] = in[22:0]. The quiet bit out[51] is copied from in[22], so a signaling NaN keeps bit 51 clear. out[28:0] is zero.
- R6: out[63] equals in[31] for every class, including -0 and negative NaN.
- R7: out_valid is in_valid delayed by one clock. A result is due on the first rising edge after the one that samples in_valid high, and back-to-back inputs give back-to-back results.
- R8: A synchronous active-high rst clears out_valid on the next rising edge.
- R9: On a cycle where in_valid is low, out_word keeps its previous value whatever in_word carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | binary32 operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_word | output | 64 | binary64 result |

## Verification
Every result is due exactly one rising edge after the edge that samples the operand. The bench drives inputs just after a falling edge and reads out_valid and out_word at the next falling edge, halfway between the capture edge and the edge after it. Back-to-back inputs are checked one per falling edge, so a result that arrives one cycle late or early shows up as a mismatch. Idle cycles and reset are checked at the same half-cycle point: out_valid must drop and out_word must hold.

// File: rtl/fwide_pkg.sv
package fwide_pkg;

  // Magnitude classes found by the front end
  typedef enum logic [1:0] {
    FW_ZERO    = 2'd0,
    FW_SUB     = 2'd1,
    FW_NORM    = 2'd2,
    FW_SPECIAL = 2'd3
  } fw_class_e;

  // Exponent bias of a format with the given exponent width
  function automatic int fw_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

  // Amount added to a source exponent to reach the destination exponent
  function automatic int fw_bias_delta(input int src_exp_w, input int dst_exp_w);
    return fw_bias(dst_exp_w) - fw_bias(src_exp_w);
  endfunction

  // Destination exponent for a subnormal renormalized by 'scale' places
  function automatic int fw_sub_exp(input int bias_delta, input int scale);
    return bias_delta + 1 - scale;
  endfunction

endpackage

// File: rtl/fwide_classify.sv
module fwide_classify
  import fwide_pkg::*;
#(
  parameter int SRC_EXP_W  = 8,
  parameter int SRC_FRAC_W = 23,
  localparam int MAG_W     = SRC_EXP_W + SRC_FRAC_W
) (
  input  logic [MAG_W-1:0] mag,
  output fw_class_e        cls
);

  localparam logic [MAG_W-1:0] MIN_NORM = {{(MAG_W-1){1'b0}}, 1'b1} << SRC_FRAC_W;
  localparam logic [MAG_W-1:0] INF_MAG  = {{SRC_EXP_W{1'b1}}, {SRC_FRAC_W{1'b0}}};

  logic [MAG_W-1:0] off_norm;
  logic             is_norm;
  logic             is_special;
  logic             is_zero;

  // One wrapping compare picks out the normal range
  assign off_norm   = mag - MIN_NORM;
  assign is_norm    = off_norm < (INF_MAG - MIN_NORM);
  assign is_special = mag >= INF_MAG;
  assign is_zero    = mag == '0;

  always_comb begin
    if (is_norm)         cls = FW_NORM;
    else if (is_special) cls = FW_SPECIAL;
    else if (is_zero)    cls = FW_ZERO;
    else                 cls = FW_SUB;
  end

endmodule

// File: rtl/fwide_lzc.sv
module fwide_lzc #(
  parameter int W      = 23,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);

  // Highest set bit wins; an all-zero vector yields W
  always_comb begin
    cnt = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CNT_W'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fwide_assemble.sv
module fwide_assemble
  import fwide_pkg::*;
#(
  parameter int SRC_EXP_W  = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DST_EXP_W  = 11,
  parameter int DST_FRAC_W = 52,
  localparam int MAG_W     = SRC_EXP_W + SRC_FRAC_W,
  localparam int CNT_W     = $clog2(SRC_FRAC_W + 1),
  localparam int DST_MAG_W = DST_EXP_W + DST_FRAC_W
) (
  input  fw_class_e            cls,
  input  logic [MAG_W-1:0]     mag,
  input  logic [CNT_W-1:0]     lz,
  output logic [DST_MAG_W-1:0] res
);

  localparam int FRAC_SHIFT = DST_FRAC_W - SRC_FRAC_W;
  localparam int BIAS_DELTA = fw_bias_delta(SRC_EXP_W, DST_EXP_W);

  logic [DST_MAG_W-1:0]  mag_ext;
  logic [DST_MAG_W-1:0]  norm_res;
  logic [DST_MAG_W-1:0]  spec_res;
  logic [DST_MAG_W-1:0]  sub_res;
  logic [DST_FRAC_W-1:0] frac_wide;
  logic [DST_FRAC_W-1:0] sub_frac;
  logic [DST_EXP_W-1:0]  sub_exp;
  logic [CNT_W-1:0]      scale;

  assign mag_ext   = DST_MAG_W'(mag);
  assign frac_wide = {mag[SRC_FRAC_W-1:0], {FRAC_SHIFT{1'b0}}};

  // Normal: move fraction and exponent up together, then rebias
  assign norm_res = (mag_ext << FRAC_SHIFT) + (DST_MAG_W'(BIAS_DELTA) << DST_FRAC_W);

  // Infinity / NaN: saturated exponent, payload left-aligned, quiet bit as-is
  assign spec_res = {{DST_EXP_W{1'b1}}, frac_wide};

  // Subnormal: the leading one is shifted out past the fraction top
  assign scale    = lz + CNT_W'(1);
  assign sub_frac = frac_wide << scale;
  assign sub_exp  = DST_EXP_W'(fw_sub_exp(BIAS_DELTA, int'(scale)));
  assign sub_res  = {sub_exp, sub_frac};

  always_comb begin
    unique case (cls)
      FW_NORM:    res = norm_res;
      FW_SPECIAL: res = spec_res;
      FW_SUB:     res = sub_res;
      default:    res = '0;
    endcase
  end

  // R2: a subnormal always has a set fraction bit, so the count stays in range
  always_comb begin
    if (cls == FW_SUB) begin
      p_sub_scale_r2: assert (lz < CNT_W'(SRC_FRAC_W));
    end
  end

endmodule

// File: rtl/f32_to_f64_widen.sv
module f32_to_f64_widen
  import fwide_pkg::*;
#(
  parameter int SRC_EXP_W  = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DST_EXP_W  = 11,
  parameter int DST_FRAC_W = 52,
  localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W,
  localparam int DST_W     = 1 + DST_EXP_W + DST_FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_word,
  output logic             out_valid,
  output logic [DST_W-1:0] out_word
);

  localparam int MAG_W     = SRC_EXP_W + SRC_FRAC_W;
  localparam int CNT_W     = $clog2(SRC_FRAC_W + 1);
  localparam int DST_MAG_W = DST_EXP_W + DST_FRAC_W;

  // Named internal events for the assertions
  logic [MAG_W-1:0]     mag_w;
  fw_class_e            cls_w;
  logic [CNT_W-1:0]     lz_w;
  logic [DST_MAG_W-1:0] mag_res_w;
  logic                 sign_w;

  assign mag_w  = in_word[MAG_W-1:0];
  assign sign_w = in_word[SRC_W-1];

  fwide_classify #(
    .SRC_EXP_W (SRC_EXP_W),
    .SRC_FRAC_W(SRC_FRAC_W)
  ) classify_i (
    .mag(mag_w),
    .cls(cls_w)
  );

  fwide_lzc #(
    .W(SRC_FRAC_W)
  ) lzc_i (
    .vec(mag_w[SRC_FRAC_W-1:0]),
    .cnt(lz_w)
  );

  fwide_assemble #(
    .SRC_EXP_W (SRC_EXP_W),
    .SRC_FRAC_W(SRC_FRAC_W),
    .DST_EXP_W (DST_EXP_W),
    .DST_FRAC_W(DST_FRAC_W)
  ) assemble_i (
    .cls(cls_w),
    .mag(mag_w),
    .lz (lz_w),
    .res(mag_res_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {sign_w, mag_res_w};
    end
  end

  // R7: the strobe follows the input strobe by one clock
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: reset clears the strobe
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R9: the result holds on idle cycles
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));

  // R6: sign carried across
  p_sign_move_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[DST_W-1] == $past(in_word[SRC_W-1]));

  // R3: zero magnitude stays zero
  p_zero_mag_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mag_w == '0) |=> out_word[DST_MAG_W-1:0] == '0);

  // R4: infinity and NaN saturate the exponent
  p_special_exp_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls_w == FW_SPECIAL) |=> &out_word[DST_W-2:DST_FRAC_W]);

  // R5: the quiet bit is copied, never forced
  p_quiet_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls_w == FW_SPECIAL) |=>
      out_word[DST_FRAC_W-1] == $past(in_word[SRC_FRAC_W-1]));

endmodule

// File: tb/f32_to_f64_widen_tb.sv
module f32_to_f64_widen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [63:0] out_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5ns clk = ~clk;

  f32_to_f64_widen dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .out_valid(out_valid),
    .out_word (out_word)
  );

  // Reference: decode, renormalize by stepping, re-encode
  function automatic logic [63:0] ref_widen(input logic [31:0] a);
    logic        s;
    logic [7:0]  e;
    logic [23:0] f;
    int          steps;
    s = a[31];
    e = a[30:23];
    f = {1'b0, a[22:0]};
    if (e == 8'hFF) return {s, 11'h7FF, a[22:0], 29'd0};
    if (e == 8'h00 && f == 24'd0) return {s, 63'd0};
    if (e == 8'h00) begin
      steps = 0;
      while (!f[23]) begin
        f = f << 1;
        steps++;
      end
      return {s, 11'(897 - steps), f[22:0], 29'd0};
    end
    return {s, 11'(int'(e) + 896), a[22:0], 29'd0};
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    if (a[30:23] == 8'hFF) return (a[22:0] != 0) ? "R5" : "R4";
    if (a[30:0] == 31'd0) return "R3";
    if (a[30:23] == 8'h00) return "R2";
    return "R1";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Compare a result; NaNs field by field, every class on sign
  task automatic check_result(input logic [31:0] a, input logic [63:0] got);
    logic [63:0] exp;
    exp = ref_widen(a);
    if (a[30:23] == 8'hFF && a[22:0] != 0) begin
      chk(got[62:52] == 11'h7FF, "R5 nan exponent", got, exp);
      chk(got[51] == a[22], "R5 quiet bit", got, exp);
      chk(got[50:29] == a[21:0], "R5 payload", got, exp);
      chk(got[28:0] == 29'd0, "R5 low fraction", got, exp);
    end else begin
      chk(got[62:0] == exp[62:0], tag_of(a), got, exp);
    end
    chk(got[63] == a[31], "R6 sign", got, exp);
  endtask

  // Drive one operand, read it back one clock later (R7)
  task automatic apply(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7 valid", 64'(out_valid), 64'd1);
    check_result(a, out_word);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] held;
    void'($urandom(32'h5EED_0042));

    // R8: reset state
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset", 64'(out_valid), 64'd0);
    rst = 1'b0;

    // Directed corners
    apply(32'h0000_0000);
    chk(out_word == 64'h0, "R3 +0", out_word, 64'h0);
    apply(32'h8000_0000);
    chk(out_word == 64'h8000_0000_0000_0000, "R3 R6 -0", out_word, 64'h8000_0000_0000_0000);
    apply(32'h3F80_0000);
    chk(out_word == 64'h3FF0_0000_0000_0000, "R1 one", out_word, 64'h3FF0_0000_0000_0000);
    apply(32'hC000_0000);
    chk(out_word == 64'hC000_0000_0000_0000, "R1 minus two", out_word, 64'hC000_0000_0000_0000);
    apply(32'h0000_0001);
    chk(out_word == 64'h36A0_0000_0000_0000, "R2 smallest", out_word, 64'h36A0_0000_0000_0000);
    apply(32'h007F_FFFF);
    apply(32'h0080_0000);
    apply(32'h7F7F_FFFF);
    apply(32'h7F80_0000);
    chk(out_word == 64'h7FF0_0000_0000_0000, "R4 +inf", out_word, 64'h7FF0_0000_0000_0000);
    apply(32'hFF80_0000);
    apply(32'h7FC0_0001);
    apply(32'h7F80_0001);
    chk(out_word[51] == 1'b0, "R5 signaling stays", out_word, 64'h7FF0_0000_2000_0000);
    apply(32'hFFFF_FFFF);

    // R7: idle cycle drops the strobe; R9: word holds despite new input
    held = out_word;
    @(negedge clk);
    in_word = 32'h1234_5678;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle", 64'(out_valid), 64'd0);
    chk(out_word == held, "R9 hold", out_word, held);

    // R7: back-to-back operands give back-to-back results
    a = 32'h4049_0FDB;
    b = 32'h0000_0300;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = a;
    @(negedge clk);
    in_word = b;
    chk(out_valid == 1'b1, "R7 burst 1", 64'(out_valid), 64'd1);
    check_result(a, out_word);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7 burst 2", 64'(out_valid), 64'd1);
    check_result(b, out_word);

    // R8: reset mid-stream with a valid input pending
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 32'h3F80_0000;
    rst      = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 mid reset", 64'(out_valid), 64'd0);
    rst      = 1'b0;
    in_valid = 1'b0;

    // Random mix biased toward subnormal, special and single-bit cases
    for (int i = 0; i < 3000; i++) begin
      int kind;
      a    = $urandom;
      kind = int'($urandom % 8);
      if (kind == 0) a[30:23] = 8'h00;
      else if (kind == 1) a[30:23] = 8'hFF;
      else if (kind == 2) begin
        a[30:23] = 8'h00;
        a[22:0]  = 23'd1 << ($urandom % 23);
      end else if (kind == 3) a[22:0] = 23'd0;
      apply(a);
      if ($urandom % 16 == 0) begin
        held = out_word;
        in_word = $urandom;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 gap", 64'(out_valid), 64'd0);
        chk(out_word == held, "R9 gap hold", out_word, held);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule